// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Controller

This block is the hazard logic for a five-stage in-order pipeline: fetch, decode, execute, memory and write-back. Each cycle it looks at the instruction in decode and the instructions held in the execute and memory pipeline registers. From these it produces three kinds of control. The first is a forwarding select for every decode-stage source operand. The second is a stall that freezes the program counter and the fetch/decode register while a bubble enters execute. The third is a squash that throws away the instruction just fetched behind a taken branch.

Operands are forwarded into decode, because branch targets and operands are prepared there. A load feeding an ALU operand in the very next instruction costs one stall cycle. A taken branch without a delay slot costs one squashed fetch slot. A branch with a delay slot costs nothing. Two structural conflicts are handled. The first arises when a data read from program memory in the memory stage occupies the port that fetch needs. The second arises when a read-modify-write bit operation, which writes data memory again in its write-back cycle, would collide with a later instruction's data-memory access. The decoder flags two-word instructions, and the controller treats the second word as operand data rather than as an instruction.

Top module: `hzd_ctrl`

## Requirements
- R1: When a used decode source index equals the execute-stage destination and the execute write-enable is set, that operand's select is 1 (execute). The select for operand i sits at fwd_sel bits [2i+1:2i], with encoding 0 = register file, 1 = execute, 2 = memory.
- R2: When a used source index matches only the memory-stage destination, and the memory write-enable is set, the select is 2 (memory).
- R3: When both the execute and the memory destinations match the same source, the execute result wins (select 1).
- R4: A source whose use flag is clear, a stage whose write-enable is clear, or an invalid decode slot gives select 0. Register 0 is compared like any other index.
- R5: An ALU-class decode instruction whose used source matches an execute-stage load destination raises stall for that cycle. When the decode instruction is not ALU-class, that match raises no stall.
- R6: A taken branch in decode with no delay slot raises squash. When squash is high, stall is low in the same cycle.
- R7: A taken branch with a delay slot, or a branch that is not taken, raises no squash.
- R8: A program-memory data read in the memory stage raises stall, whatever is in decode, unless squash is high.
- R9: A decode instruction that accesses data memory, while a read-modify-write bit operation sits in execute, raises stall.
- R10: In the cycle after an accepted first word of a two-word instruction (valid, flagged, neither stalled nor squashed), decode holds the second word. In that cycle all selects are 0, squash is low, and only the condition of R8 can stall. A stall during the second word keeps it in decode for the next cycle as well.
- R11: Reset clears the second-word tracking, so that hazard checks are active in the first cycle after reset even if a flagged first word was present during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dec_valid | input | 1 | Decode slot holds a valid word |
| dec_src | input | NSRC*RW | Decode source register indices, operand i at [RW*i +: RW] |
| dec_src_use | input | NSRC | Source operand i is read |
| dec_alu | input | 1 | Decode instruction is ALU-class |
| dec_mem | input | 1 | Decode instruction accesses data memory |
| dec_two_word | input | 1 | Decode word is the first word of a two-word instruction |
| dec_br_taken | input | 1 | Branch in decode resolved as taken |
| dec_br_dslot | input | 1 | Branch in decode has a delay slot |
| ex_rd | input | RW | Execute-stage destination index |
| ex_we | input | 1 | Execute-stage register write-enable |
| ex_load | input | 1 | Execute-stage instruction is a data-memory load |
| ex_rmw | input | 1 | Execute-stage instruction is a read-modify-write bit operation |
| mem_rd | input | RW | Memory-stage destination index |
| mem_we | input | 1 | Memory-stage register write-enable |
| mem_ldc | input | 1 | Memory-stage instruction reads data from program memory |
| fwd_sel | output | 2*NSRC | Per-operand forwarding select |
| stall | output | 1 | Hold PC and fetch/decode register, bubble into execute |
| squash | output | 1 | Discard the instruction in fetch |

## Verification
The hardest situation to reach is the second word of a two-word instruction meeting another hazard. Examples are a program-memory read stalling while the second word sits in decode, or a first word that is stalled and therefore must not arm the tracking. Random stimulus sets the two-word flag often and keeps register indices in a small range, so such overlaps come up often. Directed sequences set up a flagged first word and then raise the program-memory read or a matching destination on the following cycles.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

    typedef enum logic [1:0] {
        FWD_RF  = 2'd0,
        FWD_EX  = 2'd1,
        FWD_MEM = 2'd2
    } fwd_sel_e;

    typedef struct packed {
        logic second;
    } hzd_state_t;

endpackage

// File: rtl/hzd_fwd_lane.sv
module hzd_fwd_lane
    import hzd_pkg::*;
#(
    parameter int RW = 4
) (
    input  logic          chk,
    input  logic [RW-1:0] src,
    input  logic          src_used,
    input  logic [RW-1:0] ex_rd,
    input  logic          ex_we,
    input  logic          ex_load,
    input  logic [RW-1:0] mem_rd,
    input  logic          mem_we,
    output fwd_sel_e      sel,
    output logic          ld_hit
);
    logic ex_hit;
    logic mem_hit;

    always_comb begin
        ex_hit  = chk & src_used & ex_we  & (ex_rd  == src);
        mem_hit = chk & src_used & mem_we & (mem_rd == src);
        // the younger execute result has priority
        if (ex_hit)       sel = FWD_EX;
        else if (mem_hit) sel = FWD_MEM;
        else              sel = FWD_RF;
        ld_hit = ex_hit & ex_load;
    end
endmodule

// File: rtl/hzd_stall_arb.sv
module hzd_stall_arb #(
    parameter int NSRC = 2
) (
    input  logic            chk,
    input  logic            dec_alu,
    input  logic            dec_mem,
    input  logic            dec_br_taken,
    input  logic            dec_br_dslot,
    input  logic [NSRC-1:0] ld_hit,
    input  logic            ex_rmw,
    input  logic            mem_ldc,
    output logic            stall,
    output logic            squash
);
    logic load_use;
    logic rmw_clash;
    logic raw_stall;

    always_comb begin
        squash    = chk & dec_br_taken & ~dec_br_dslot;
        load_use  = dec_alu & (|ld_hit);
        rmw_clash = chk & dec_mem & ex_rmw;
        raw_stall = mem_ldc | load_use | rmw_clash;
        stall     = raw_stall & ~squash;
    end
endmodule

// File: rtl/hzd_ctrl.sv
module hzd_ctrl
    import hzd_pkg::*;
#(
    parameter int NREG = 16,
    parameter int NSRC = 2,
    localparam int RW  = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dec_valid,
    input  logic [NSRC*RW-1:0] dec_src,
    input  logic [NSRC-1:0]   dec_src_use,
    input  logic              dec_alu,
    input  logic              dec_mem,
    input  logic              dec_two_word,
    input  logic              dec_br_taken,
    input  logic              dec_br_dslot,
    input  logic [RW-1:0]     ex_rd,
    input  logic              ex_we,
    input  logic              ex_load,
    input  logic              ex_rmw,
    input  logic [RW-1:0]     mem_rd,
    input  logic              mem_we,
    input  logic              mem_ldc,
    output logic [2*NSRC-1:0] fwd_sel,
    output logic              stall,
    output logic              squash
);
    hzd_state_t st_d;
    hzd_state_t st_q;
    logic       chk;
    logic [NSRC-1:0] ld_hit;

    assign chk = dec_valid & ~st_q.second;

    for (genvar i = 0; i < NSRC; i++) begin : g_lane
        fwd_sel_e lane_sel;
        hzd_fwd_lane #(.RW(RW)) u_lane (
            .chk      (chk),
            .src      (dec_src[RW*i +: RW]),
            .src_used (dec_src_use[i]),
            .ex_rd    (ex_rd),
            .ex_we    (ex_we),
            .ex_load  (ex_load),
            .mem_rd   (mem_rd),
            .mem_we   (mem_we),
            .sel      (lane_sel),
            .ld_hit   (ld_hit[i])
        );
        assign fwd_sel[2*i +: 2] = lane_sel;
    end

    hzd_stall_arb #(.NSRC(NSRC)) u_arb (
        .chk          (chk),
        .dec_alu      (dec_alu),
        .dec_mem      (dec_mem),
        .dec_br_taken (dec_br_taken),
        .dec_br_dslot (dec_br_dslot),
        .ld_hit       (ld_hit),
        .ex_rmw       (ex_rmw),
        .mem_ldc      (mem_ldc),
        .stall        (stall),
        .squash       (squash)
    );

    always_comb begin
        st_d = st_q;
        if (st_q.second) begin
            // a held second word stays in decode
            st_d.second = stall;
        end else begin
            st_d.second = chk & dec_two_word & ~stall & ~squash;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/hzd_ctrl_chk.sv
module hzd_ctrl_chk #(
    parameter int NREG = 16,
    parameter int NSRC = 2,
    localparam int RW  = $clog2(NREG)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dec_valid,
    input logic [NSRC*RW-1:0] dec_src,
    input logic [NSRC-1:0]   dec_src_use,
    input logic              dec_alu,
    input logic              dec_mem,
    input logic              dec_two_word,
    input logic              dec_br_taken,
    input logic              dec_br_dslot,
    input logic [RW-1:0]     ex_rd,
    input logic              ex_we,
    input logic              ex_load,
    input logic              ex_rmw,
    input logic [RW-1:0]     mem_rd,
    input logic              mem_we,
    input logic              mem_ldc,
    input logic [2*NSRC-1:0] fwd_sel,
    input logic              stall,
    input logic              squash,
    input logic              second_q
);
    // R1
    ex_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !second_q && dec_src_use[0] && ex_we && ex_rd == dec_src[RW-1:0])
        |-> fwd_sel[1:0] == 2'd1);

    // R4
    idle_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> fwd_sel == '0);

    // R5
    load_use_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !second_q && dec_alu && dec_src_use[0] && ex_we && ex_load
         && ex_rd == dec_src[RW-1:0] && !squash) |-> stall);

    // R6
    squash_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        squash |-> !stall);

    // R7
    dslot_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_br_dslot || !dec_br_taken) |-> !squash);

    // R8
    ldc_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_ldc && !squash) |-> stall);

    // R9
    rmw_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !second_q && dec_mem && ex_rmw && !squash) |-> stall);

    // R10
    second_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_two_word && !second_q && !stall && !squash)
        |=> (fwd_sel == '0 && !squash && (stall == mem_ldc)));

    // R10
    second_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (second_q && stall) |=> second_q);

    logic unused_ok;
    assign unused_ok = &{1'b0, mem_rd, mem_we, dec_src_use[NSRC-1:0]};
endmodule

bind hzd_ctrl hzd_ctrl_chk #(.NREG(NREG), .NSRC(NSRC)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .dec_valid    (dec_valid),
    .dec_src      (dec_src),
    .dec_src_use  (dec_src_use),
    .dec_alu      (dec_alu),
    .dec_mem      (dec_mem),
    .dec_two_word (dec_two_word),
    .dec_br_taken (dec_br_taken),
    .dec_br_dslot (dec_br_dslot),
    .ex_rd        (ex_rd),
    .ex_we        (ex_we),
    .ex_load      (ex_load),
    .ex_rmw       (ex_rmw),
    .mem_rd       (mem_rd),
    .mem_we       (mem_we),
    .mem_ldc      (mem_ldc),
    .fwd_sel      (fwd_sel),
    .stall        (stall),
    .squash       (squash),
    .second_q     (st_q.second)
);

// File: tb/hzd_ctrl_tb.sv
module hzd_ctrl_tb;
    localparam int NREG = 16;
    localparam int NSRC = 2;
    localparam int RW   = $clog2(NREG);

    logic              clk = 1'b0;
    logic              rst_n;
    logic              dec_valid, dec_alu, dec_mem, dec_two_word;
    logic              dec_br_taken, dec_br_dslot;
    logic [NSRC*RW-1:0] dec_src;
    logic [NSRC-1:0]   dec_src_use;
    logic [RW-1:0]     ex_rd, mem_rd;
    logic              ex_we, ex_load, ex_rmw, mem_we, mem_ldc;
    logic [2*NSRC-1:0] fwd_sel;
    logic              stall, squash;

    int n_checks = 0;
    int n_fail   = 0;
    logic m_second;
    logic [2*NSRC-1:0] e_sel;
    logic e_stall, e_squash;

    always #5 clk = ~clk;

    hzd_ctrl #(.NREG(NREG), .NSRC(NSRC)) u_dut (.*);

    initial begin
        #2000000;
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    // expected outputs from the requirements, with a model of the second-word flag
    task automatic model();
        logic ck, ld, sq;
        ck = dec_valid & ~m_second;
        ld = 1'b0;
        e_sel = '0;
        for (int i = 0; i < NSRC; i++) begin
            logic [RW-1:0] s;
            s = dec_src[RW*i +: RW];
            if (ck && dec_src_use[i] && ex_we && ex_rd == s) begin
                e_sel[2*i +: 2] = 2'd1;
                if (ex_load) ld = 1'b1;
            end else if (ck && dec_src_use[i] && mem_we && mem_rd == s) begin
                e_sel[2*i +: 2] = 2'd2;
            end
        end
        sq = ck & dec_br_taken & ~dec_br_dslot;
        e_squash = sq;
        e_stall  = ~sq & (mem_ldc | (ck & dec_alu & ld) | (ck & dec_mem & ex_rmw));
    endtask

    task automatic idle();
        dec_valid = 0; dec_src = '0; dec_src_use = '0; dec_alu = 0; dec_mem = 0;
        dec_two_word = 0; dec_br_taken = 0; dec_br_dslot = 0;
        ex_rd = '0; ex_we = 0; ex_load = 0; ex_rmw = 0;
        mem_rd = '0; mem_we = 0; mem_ldc = 0;
    endtask

    task automatic randomize_in();
        logic big;
        big = ($urandom % 8) == 0;
        dec_valid    = ($urandom % 8) != 0;
        for (int i = 0; i < NSRC; i++)
            dec_src[RW*i +: RW] = RW'(big ? $urandom % NREG : $urandom % 3);
        dec_src_use  = NSRC'($urandom);
        dec_alu      = $urandom % 2;
        dec_mem      = ($urandom % 3) == 0;
        dec_two_word = ($urandom % 4) == 0;
        dec_br_taken = ($urandom % 6) == 0;
        dec_br_dslot = $urandom % 2;
        ex_rd        = RW'(big ? $urandom % NREG : $urandom % 3);
        ex_we        = ($urandom % 4) != 0;
        ex_load      = ($urandom % 3) == 0;
        ex_rmw       = ($urandom % 6) == 0;
        mem_rd       = RW'(big ? $urandom % NREG : $urandom % 3);
        mem_we       = ($urandom % 4) != 0;
        mem_ldc      = ($urandom % 10) == 0;
    endtask

    // inputs already applied after a falling edge; check, then advance the model
    task automatic run_cycle(input string tag);
        #1;
        model();
        check({tag, " R1/R2/R3/R4/R10 fwd_sel"}, 8'(fwd_sel), 8'(e_sel));
        check({tag, " R5/R8/R9/R10 stall"}, 8'(stall), 8'(e_stall));
        check({tag, " R6/R7 squash"}, 8'(squash), 8'(e_squash));
        @(posedge clk);
        if (m_second) m_second = e_stall;
        else m_second = dec_valid & dec_two_word & ~e_stall & ~e_squash;
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd2024));
        m_second = 0;
        idle();
        rst_n = 0;
        // R11: flagged first word present during reset
        dec_valid = 1; dec_two_word = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        dec_two_word = 0;
        dec_src = 8'h21; dec_src_use = 2'b01; ex_rd = 4'h1; ex_we = 1;
        #1;
        check("R11 reset state sel", 8'(fwd_sel), 8'h01);
        check("R11 reset state stall", 8'(stall), 8'h0);
        run_cycle("R11");

        // R3: both stages match
        idle(); dec_valid = 1; dec_src = 8'h33; dec_src_use = 2'b11;
        ex_rd = 4'h3; ex_we = 1; mem_rd = 4'h3; mem_we = 1;
        #1; check("R3 ex priority", 8'(fwd_sel), 8'h05);
        run_cycle("R3");

        // R4: register 0 ordinary, write-enable gating
        idle(); dec_valid = 1; dec_src = 8'h00; dec_src_use = 2'b01; ex_rd = 0; ex_we = 1;
        #1; check("R4 reg0 forwarded", 8'(fwd_sel), 8'h01);
        run_cycle("R4");
        idle(); dec_valid = 1; dec_src = 8'h00; dec_src_use = 2'b11; ex_rd = 0; mem_rd = 0;
        #1; check("R4 no write-enable", 8'(fwd_sel), 8'h00);
        run_cycle("R4");

        // R5: non-ALU consumer of a load
        idle(); dec_valid = 1; dec_src = 8'h05; dec_src_use = 2'b01;
        ex_rd = 5; ex_we = 1; ex_load = 1; dec_alu = 0;
        #1; check("R5 non-ALU no stall", 8'(stall), 8'h0);
        run_cycle("R5");
        dec_alu = 1;
        #1; check("R5 load-use stall", 8'(stall), 8'h1);
        run_cycle("R5");

        // R6: squash beats program-memory stall
        idle(); dec_valid = 1; dec_br_taken = 1; mem_ldc = 1;
        #1; check("R6 squash", 8'(squash), 8'h1);
        check("R6 stall low under squash", 8'(stall), 8'h0);
        run_cycle("R6");
        dec_br_dslot = 1;
        #1; check("R7 delay slot kept", 8'(squash), 8'h0);
        run_cycle("R7");

        // R9
        idle(); dec_valid = 1; dec_mem = 1; ex_rmw = 1;
        #1; check("R9 rmw clash", 8'(stall), 8'h1);
        run_cycle("R9");

        // R10: second word with program-memory stall, then held
        idle(); dec_valid = 1; dec_two_word = 1;
        run_cycle("R10 first");
        idle(); dec_valid = 1; dec_src = 8'h11; dec_src_use = 2'b11;
        ex_rd = 1; ex_we = 1; ex_load = 1; dec_alu = 1; dec_br_taken = 1; mem_ldc = 1;
        #1; check("R10 second sel", 8'(fwd_sel), 8'h00);
        check("R10 second squash", 8'(squash), 8'h0);
        check("R10 second ldc stall", 8'(stall), 8'h1);
        run_cycle("R10 held");
        mem_ldc = 0;
        #1; check("R10 still second", 8'(fwd_sel), 8'h00);
        run_cycle("R10 release");
        #1; check("R10 checks back", 8'(fwd_sel), 8'h05);
        run_cycle("R10 after");

        // R10: stalled first word does not arm
        idle(); dec_valid = 1; dec_two_word = 1; mem_ldc = 1;
        run_cycle("R10 stalled first");
        idle(); dec_valid = 1; dec_src = 8'h02; dec_src_use = 2'b01; mem_rd = 2; mem_we = 1;
        #1; check("R2/R10 not armed", 8'(fwd_sel), 8'h02);
        run_cycle("R2");

        for (int n = 0; n < 3000; n++) begin
            randomize_in();
            run_cycle("rand");
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule